// File: doc/BRIEF.md
# Programmable Pulse Burst Generator

This block sends a finite train of square-wave pulses on a single output line. Two tick strobes arrive as single-cycle enables in the block's clock domain: a primary one and an auxiliary one. A select bit picks one of them. A prescaler divides the chosen tick stream by a power of two given by a 3-bit exponent. A toggle stage then halves that rate again, so every high phase and every low phase of the output lasts 2^N selected ticks.

A start strobe begins one burst. On that strobe the block captures the exponent, the source select and an 8-bit length, so it emits length+1 pulses. The block then runs until the last pulse has fallen. It reports a busy level for the whole burst and a one-clock done strobe at the end. Between bursts the output sits low. Configuration inputs may change at any time; they are only sampled when a burst is accepted.

Top module: `pulse_burst_gen`

## Requirements
- R1: With `cfg_src_sel` = 0 only `tick_prim` strobes advance the burst; with `cfg_src_sel` = 1 only `tick_aux` strobes do, and strobes on the other input have no effect.
- R2: Every high phase of `burst_out` lasts exactly 2^N selected ticks, where N is the value of `cfg_div_exp` (0 gives 1 tick, 7 gives 128 ticks).
- R3: The low phase from start to the first rising edge, and each low phase between pulses of a burst, last exactly 2^N selected ticks.
- R4: A burst holds exactly `cfg_burst_len`+1 pulses, so a value of 0 gives one pulse and 255 gives 256 pulses.
- R5: After reset, `burst_out`, `busy` and `done` are 0. While no burst runs, `burst_out` stays 0 whatever the tick inputs do.
- R6: A `start` strobe while idle sets `busy` at the next clock edge with `burst_out` still 0.
- R7: A `start` strobe during a burst is ignored: the pulse count and timing of that burst are unchanged.
- R8: Changes to `cfg_div_exp`, `cfg_src_sel` or `cfg_burst_len` during a burst do not alter that burst.
- R9: At the edge where the last pulse falls, `done` goes high for exactly one cycle and `busy` drops in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div_exp | input | 3 | Prescaler exponent N (divide by 2^N) |
| cfg_src_sel | input | 1 | Tick source select: 0 primary, 1 auxiliary |
| cfg_burst_len | input | 8 | Pulses per burst minus one |
| tick_prim | input | 1 | Primary tick strobe |
| tick_aux | input | 1 | Auxiliary tick strobe |
| start | input | 1 | Burst start strobe |
| busy | output | 1 | High while a burst is running |
| done | output | 1 | One-cycle strobe when a burst completes |
| burst_out | output | 1 | Pulse output |

## Verification
`busy` appears one edge after an accepted start. A tick driven in one cycle acts at the next rising edge, and any toggle of `burst_out` is visible from that edge. `done` comes in the same edge as the final falling edge, and it clears one edge later. The bench drives inputs on the falling clock edge and samples on the next falling edge. It credits each selected tick to the output level that was present before the edge that consumes the tick. This lets the phase lengths be compared with 2^N exactly. It checks the done strobe and the idle level on the two falling edges that follow completion.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

   typedef enum logic {
      PBG_IDLE = 1'b0,
      PBG_RUN  = 1'b1
   } pbg_state_e;

   // Width of a counter able to hold 2^(2^exp_w - 1) - 1
   function automatic int presc_width(input int exp_w);
      return (1 << exp_w) - 1;
   endfunction

endpackage

// File: rtl/pbg_tick_sel.sv
module pbg_tick_sel (
   input  logic tick_prim,
   input  logic tick_aux,
   input  logic sel_aux,
   input  logic enable,
   output logic tick
);

   always_comb begin
      tick = enable & (sel_aux ? tick_aux : tick_prim);
   end

endmodule

// File: rtl/pbg_prescaler.sv
module pbg_prescaler #(
   parameter int EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             div_pulse
);

   localparam int CNT_W = pbg_pkg::presc_width(EXP_W);

   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp_w
      $error("pbg_prescaler: EXP_W must lie in 1..5");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   // Terminal value has its lowest exp_sel bits set
   for (genvar i = 0; i < CNT_W; i++) begin : g_limit
      assign limit[i] = (i < int'(exp_sel));
   end

   assign div_pulse = tick && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= div_pulse ? '0 : cnt + 1'b1;
      end
   end

   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);

   // R1
   div_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> tick);

   // R3
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/pbg_burst_ctrl.sv
module pbg_burst_ctrl #(
   parameter int EXP_W = 3,
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [EXP_W-1:0] cfg_exp,
   input  logic             cfg_src,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             div_pulse,
   output logic [EXP_W-1:0] run_exp,
   output logic             run_src,
   output logic             presc_clr,
   output logic             busy,
   output logic             done,
   output logic             pulse_out
);

   import pbg_pkg::*;

   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len_w
      $error("pbg_burst_ctrl: LEN_W must lie in 1..16");
   end

   pbg_state_e       state;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] pulse_cnt;
   logic             accept;

   assign busy      = (state == PBG_RUN);
   assign accept    = start && !busy;
   assign presc_clr = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PBG_IDLE;
         run_exp   <= '0;
         run_src   <= 1'b0;
         len_q     <= '0;
         pulse_cnt <= '0;
         pulse_out <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            state     <= PBG_RUN;
            run_exp   <= cfg_exp;
            run_src   <= cfg_src;
            len_q     <= cfg_len;
            pulse_cnt <= '0;
            pulse_out <= 1'b0;
         end else if (busy && div_pulse) begin
            if (!pulse_out) begin
               pulse_out <= 1'b1;
            end else begin
               pulse_out <= 1'b0;
               if (pulse_cnt == len_q) begin
                  state <= PBG_IDLE;
                  done  <= 1'b1;
               end else begin
                  pulse_cnt <= pulse_cnt + 1'b1;
               end
            end
         end
      end
   end

   // R5
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pulse_out);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pulse_cnt <= len_q));

   // R7
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(len_q) && $stable(run_exp) && $stable(run_src)));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !div_pulse) |=> ($stable(pulse_out) && $stable(pulse_cnt)));

   // R6
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !pulse_out);

endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen #(
   parameter int EXP_W = 3,
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXP_W-1:0] cfg_div_exp,
   input  logic             cfg_src_sel,
   input  logic [LEN_W-1:0] cfg_burst_len,
   input  logic             tick_prim,
   input  logic             tick_aux,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             burst_out
);

   logic [EXP_W-1:0] run_exp;
   logic             run_src;
   logic             presc_clr;
   logic             sel_tick;
   logic             div_pulse;

   pbg_tick_sel u_sel (
      .tick_prim (tick_prim),
      .tick_aux  (tick_aux),
      .sel_aux   (run_src),
      .enable    (busy),
      .tick      (sel_tick)
   );

   pbg_prescaler #(.EXP_W(EXP_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (presc_clr),
      .tick      (sel_tick),
      .exp_sel   (run_exp),
      .div_pulse (div_pulse)
   );

   pbg_burst_ctrl #(.EXP_W(EXP_W), .LEN_W(LEN_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_exp   (cfg_div_exp),
      .cfg_src   (cfg_src_sel),
      .cfg_len   (cfg_burst_len),
      .div_pulse (div_pulse),
      .run_exp   (run_exp),
      .run_src   (run_src),
      .presc_clr (presc_clr),
      .busy      (busy),
      .done      (done),
      .pulse_out (burst_out)
   );

endmodule

// File: tb/tb_pulse_burst_gen.sv
module tb_pulse_burst_gen;

   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_div_exp = '0;
   logic       cfg_src_sel = 1'b0;
   logic [7:0] cfg_burst_len = '0;
   logic       tick_prim = 1'b0;
   logic       tick_aux = 1'b0;
   logic       start = 1'b0;
   logic       busy, done, burst_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PER/2) clk = ~clk;

   pulse_burst_gen dut (
      .clk(clk), .rst_n(rst_n), .cfg_div_exp(cfg_div_exp), .cfg_src_sel(cfg_src_sel),
      .cfg_burst_len(cfg_burst_len), .tick_prim(tick_prim), .tick_aux(tick_aux),
      .start(start), .busy(busy), .done(done), .burst_out(burst_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic void step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endfunction

   // mode: 0 plain, 1 start during burst (R7), 2 config change during burst (R8)
   task automatic run_burst(input int n, input int len, input bit src, input int mode);
      int seg = 0;
      int rises = 0;
      int cyc = 0;
      bit last = 1'b0;
      bit sel;
      int want = 1 << n;
      string tag;
      tag = (mode == 1) ? "R7" : (mode == 2) ? "R8" : "R4";
      @(negedge clk);
      cfg_div_exp = 3'(n); cfg_src_sel = src; cfg_burst_len = 8'(len);
      tick_prim = 1'b0; tick_aux = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
      chk(burst_out == 1'b0, "R6 output low at start", int'(burst_out), 0);
      forever begin
         step_lfsr();
         tick_prim = lfsr[0];
         tick_aux  = lfsr[7];
         start = (mode == 1 && (cyc == 4 || cyc == 9));
         if (mode == 2 && cyc == 3) begin
            cfg_div_exp = 3'(n + 1); cfg_src_sel = ~src; cfg_burst_len = 8'(len + 2);
         end
         sel = src ? tick_aux : tick_prim;
         if (sel) seg++;
         @(negedge clk);
         cyc++;
         if (burst_out != last) begin
            if (last) chk(seg == want, "R2 high phase ticks", seg, want);
            else      chk(seg == want, "R3 low phase ticks", seg, want);
            if (src) chk(seg == want, "R1 aux source selected", seg, want);
            else     chk(seg == want, "R1 prim source selected", seg, want);
            if (burst_out) rises++;
            seg = 0;
            last = burst_out;
         end
         if (done) break;
         if (cyc > 6000) begin
            chk(1'b0, "R4 burst never ended", cyc, 0);
            break;
         end
      end
      start = 1'b0;
      tick_prim = 1'b0; tick_aux = 1'b0;
      chk(busy == 1'b0, "R9 busy drops with done", int'(busy), 0);
      chk(burst_out == 1'b0, "R9 output low at done", int'(burst_out), 0);
      chk(rises == len + 1, {tag, " pulse count"}, rises, len + 1);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
      cfg_div_exp = '0; cfg_src_sel = 1'b0; cfg_burst_len = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit idle_ok;
      repeat (3) @(negedge clk);
      chk(burst_out == 1'b0, "R5 reset output", int'(burst_out), 0);
      chk(busy == 1'b0, "R5 reset busy", int'(busy), 0);
      chk(done == 1'b0, "R5 reset done", int'(done), 0);
      rst_n = 1'b1;
      for (int s = 0; s < 2; s++)
         for (int n = 0; n < 4; n++)
            for (int l = 0; l < 4; l++)
               run_burst(n, (l == 3) ? 5 : l, s[0], 0);
      run_burst(7, 1, 1'b0, 0);
      run_burst(0, 255, 1'b1, 0);
      run_burst(2, 3, 1'b0, 1);
      run_burst(1, 2, 1'b1, 2);
      idle_ok = 1'b1;
      for (int i = 0; i < 30; i++) begin
         tick_prim = 1'b1; tick_aux = i[0];
         @(negedge clk);
         if (burst_out || busy) idle_ok = 1'b0;
      end
      chk(idle_ok, "R5 idle output with ticks", int'(!idle_ok), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule